// File: doc/BRIEF.md
# Program Sequencer for a Nibble-Wide Processor

This block produces the 12-bit instruction fetch address of a small 4-bit accumulator machine. It receives each instruction byte as it is fetched. It works out whether the opcode needs a second byte, and it holds that first byte until the second one arrives. It then picks the next address from one of several sources: the incremented PC, an absolute 12-bit target, a target within the current 256-word page, a register pair, or a small internal return stack.

Flag inputs come from the datapath: accumulator zero, carry, the level of the test pin, and the value of the selected register after it has been incremented. The block samples these inputs in the cycle that resolves the branch. A return instruction also raises a one-cycle request that loads the instruction's 4-bit immediate into the accumulator.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset sets `pc` to 0x000, puts the block in the first-word state (`want_second`=0) and empties the return stack. A return that follows the reset goes to 0x000.
- R2: A valid one-word instruction other than an indirect jump or a return sets `pc` to `pc`+1. The address wraps from 0xFFF to 0x000.
- R3: While `word_vld` is low, `pc`, `want_second` and the stack do not change.
- R4: The two-word opcodes are high nibble 0x1, 0x2 with bit 0 clear, 0x4, 0x5 and 0x7. When the first word of one of these is accepted, `want_second` goes to 1 and `pc` advances by 1. When the second word is accepted, `want_second` returns to 0. The fetch-immediate form (0x2, even) then simply advances `pc`.
- R5: A long jump (first word 0x4a, second word bb) sets `pc` to {a, bb}.
- R6: The conditional jump (first word 0x1c) uses c[3] as invert, c[2] for accumulator zero, c[1] for carry set and c[0] for test pin low. The enabled tests are ORed, and the result is XORed with c[3]. The flags are sampled with the second word. So c=0000 never jumps and c=1000 always jumps.
- R7: A short target (conditional jump, increment-and-skip, indirect jump) replaces bits 7..0 only. Bits 11..8 come from the address of the word after the instruction, so an instruction that ends on the last word of a page branches into the next page.
- R8: Increment-and-skip (first word 0x7r, second word bb) branches to bb when `reg_inc` is nonzero. When `reg_inc` is zero it falls through to the next word.
- R9: An indirect jump (one word, 0x3 with bit 0 set) takes bits 7..0 from `pair_val`.
- R10: A call (first word 0x5a, second word bb) pushes the address after the second word and sets `pc` to {a, bb}.
- R11: A return (one word, 0xCd) pops the stack into `pc`. In that same cycle it drives `acc_wr`=1 with `acc_data`=d. `acc_wr` is 0 in every other cycle.
- R12: The stack holds 3 entries. A fourth push discards the oldest entry. A pop from an empty stack returns the most recently popped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | An instruction byte is present this cycle |
| word | input | 8 | Instruction byte fetched from `pc` |
| acc_zero | input | 1 | Accumulator equals zero |
| carry | input | 1 | Carry flag |
| tst | input | 1 | Test pin level |
| reg_inc | input | 4 | Selected register after increment |
| pair_val | input | 8 | Selected register pair value |
| pc | output | 12 | Address of the next fetch |
| want_second | output | 1 | Next accepted byte is a second word |
| acc_wr | output | 1 | Load accumulator with `acc_data` |
| acc_data | output | 4 | Return immediate |

## Verification
The bench places short branches on the last word of a page. A design that took the high nibble from the instruction's own address would stay in the old page. It sweeps condition codes that combine several tests, and it checks both the inverted and the uninverted form. A design with a wrong bit order or an AND in place of the OR would branch the wrong way. The bench makes four nested calls and then pops past empty. This exposes a stack that keeps the oldest entry or returns garbage on underflow. A reset in the middle of a run shows whether stale return addresses survive.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int DEPTH = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        word_vld,
  input  logic [7:0]  word,
  input  logic        acc_zero,
  input  logic        carry,
  input  logic        tst,
  input  logic [3:0]  reg_inc,
  input  logic [7:0]  pair_val,
  output logic [11:0] pc,
  output logic        want_second,
  output logic        acc_wr,
  output logic [3:0]  acc_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]  w1;
  logic [11:0] stk [DEPTH];
  logic [11:0] last_pop;
  logic [CW-1:0] cnt;

  logic [3:0]  op, fop;
  logic [11:0] pc_inc, pc_nxt, pop_val;
  logic        two, take, push, pop;

  assign op      = word[7:4];
  assign fop     = w1[7:4];
  assign pc_inc  = pc + 12'd1;
  assign two     = (op == 4'h1) || (op == 4'h2 && !word[0]) ||
                   (op == 4'h4) || (op == 4'h5) || (op == 4'h7);
  assign take    = (|(w1[2:0] & {acc_zero, carry, ~tst})) ^ w1[3];
  assign pop_val = (cnt != '0) ? stk[0] : last_pop;
  assign acc_wr  = word_vld && !want_second && op == 4'hC;
  assign acc_data = word[3:0];

  always_comb begin
    push   = 1'b0;
    pop    = 1'b0;
    pc_nxt = pc;
    if (word_vld) begin
      pc_nxt = pc_inc;
      if (!want_second) begin
        if (op == 4'h3 && word[0]) begin
          pc_nxt = {pc_inc[11:8], pair_val};
        end else if (op == 4'hC) begin
          pop    = 1'b1;
          pc_nxt = pop_val;
        end
      end else begin
        case (fop)
          4'h1: if (take) pc_nxt = {pc_inc[11:8], word};
          4'h4: pc_nxt = {w1[3:0], word};
          4'h5: begin
            push   = 1'b1;
            pc_nxt = {w1[3:0], word};
          end
          4'h7: if (reg_inc != 4'h0) pc_nxt = {pc_inc[11:8], word};
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= '0;
      want_second <= 1'b0;
      w1          <= '0;
    end else begin
      pc <= pc_nxt;
      if (word_vld) begin
        want_second <= !want_second && two;
        if (!want_second) w1 <= word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      last_pop <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push) begin
      stk[0] <= pc_inc;
      for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
      if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
    end else if (pop && cnt != '0) begin
      last_pop <= stk[0];
      for (int i = 0; i < DEPTH - 1; i++) stk[i] <= stk[i+1];
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk (
  input logic        clk,
  input logic        rst,
  input logic        word_vld,
  input logic [7:0]  word,
  input logic [11:0] pc,
  input logic        want_second,
  input logic        acc_wr,
  input logic [3:0]  acc_data
);
  logic [7:0] first_q;
  logic [3:0] op;
  logic       two;

  assign op  = word[7:4];
  assign two = (op == 4'h1) || (op == 4'h2 && !word[0]) ||
               (op == 4'h4) || (op == 4'h5) || (op == 4'h7);

  always_ff @(posedge clk) begin
    if (rst) first_q <= '0;
    else if (word_vld && !want_second) first_q <= word;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !word_vld |=> $stable(pc) && $stable(want_second));

  assert_first_R4: assert property (@(posedge clk) disable iff (rst)
    word_vld && !want_second && two |=> want_second && pc == $past(pc) + 12'd1);

  assert_second_R4: assert property (@(posedge clk) disable iff (rst)
    word_vld && want_second |=> !want_second);

  assert_ljmp_R5: assert property (@(posedge clk) disable iff (rst)
    word_vld && want_second && first_q[7:4] == 4'h4 |=>
      pc == {$past(first_q[3:0]), $past(word)});

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    word_vld && !want_second && !two && op != 4'h3 && op != 4'hC |=>
      pc == $past(pc) + 12'd1);

  assert_accwr_R11: assert property (@(posedge clk) disable iff (rst)
    acc_wr |-> word_vld && !want_second && op == 4'hC && acc_data == word[3:0]);
endmodule

bind pc_sequencer pc_sequencer_chk i_chk (
  .clk(clk), .rst(rst), .word_vld(word_vld), .word(word), .pc(pc),
  .want_second(want_second), .acc_wr(acc_wr), .acc_data(acc_data)
);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic [7:0]  word = '0;
  logic        acc_zero = 1'b0, carry = 1'b0, tst = 1'b1;
  logic [3:0]  reg_inc = '0;
  logic [7:0]  pair_val = '0;
  logic [11:0] pc;
  logic        want_second, acc_wr;
  logic [3:0]  acc_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
    .acc_zero(acc_zero), .carry(carry), .tst(tst), .reg_inc(reg_inc),
    .pair_val(pair_val), .pc(pc), .want_second(want_second),
    .acc_wr(acc_wr), .acc_data(acc_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] w);
    word = w;
    word_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_vld = 1'b0;
  endtask

  task automatic goto(input logic [11:0] a);
    step({4'h4, a[11:8]});
    step(a[7:0]);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pc", pc, 12'h000);
    chk("R1 want_second", want_second, 0);
  endtask

  task automatic t_seq();
    goto(12'h010);
    step(8'h00); chk("R2 nop", pc, 12'h011);
    step(8'hF2); chk("R2 accop", pc, 12'h012);
    step(8'h21); chk("R2 odd 2x", pc, 12'h013);
    step(8'h30); chk("R2 even 3x", pc, 12'h014);
    goto(12'hFFF);
    step(8'h00); chk("R2 wrap", pc, 12'h000);
  endtask

  task automatic t_hold();
    goto(12'h123);
    repeat (3) @(negedge clk);
    chk("R3 idle pc", pc, 12'h123);
    step(8'h4F);
    repeat (2) @(negedge clk);
    chk("R3 idle mid pc", pc, 12'h124);
    chk("R3 idle mid state", want_second, 1);
    step(8'h00);
    chk("R3 resume", pc, 12'hF00);
  endtask

  task automatic t_fim();
    goto(12'h200);
    step(8'h24);
    chk("R4 first pc", pc, 12'h201);
    chk("R4 first flag", want_second, 1);
    step(8'h99);
    chk("R4 second pc", pc, 12'h202);
    chk("R4 second flag", want_second, 0);
  endtask

  task automatic t_long();
    goto(12'hABC);
    chk("R5 long", pc, 12'hABC);
  endtask

  task automatic jcn(input logic [3:0] c, input logic az, input logic cy,
                     input logic t, input bit taken);
    goto(12'h300);
    acc_zero = az; carry = cy; tst = t;
    step({4'h1, c});
    step(8'h40);
    chk($sformatf("R6 cond c=%b", c), pc, taken ? 12'h340 : 12'h302);
    acc_zero = 1'b0; carry = 1'b0; tst = 1'b1;
  endtask

  task automatic t_cond();
    jcn(4'b0000, 1, 1, 0, 0);
    jcn(4'b1000, 0, 0, 1, 1);
    jcn(4'b0100, 1, 0, 1, 1);
    jcn(4'b0100, 0, 1, 0, 0);
    jcn(4'b0010, 0, 1, 1, 1);
    jcn(4'b0001, 0, 0, 0, 1);
    jcn(4'b0001, 0, 0, 1, 0);
    jcn(4'b1100, 1, 0, 1, 0);
    jcn(4'b1100, 0, 0, 1, 1);
    jcn(4'b0110, 0, 1, 1, 1);
    jcn(4'b0111, 0, 0, 1, 0);
  endtask

  task automatic t_page();
    goto(12'h3FE);
    step(8'h18); step(8'h20);
    chk("R7 cond page", pc, 12'h420);
    goto(12'h3FF);
    pair_val = 8'h77;
    step(8'h31);
    chk("R7 indirect page", pc, 12'h477);
    goto(12'h7FE);
    reg_inc = 4'h5;
    step(8'h73); step(8'h20);
    chk("R7 isz page", pc, 12'h820);
  endtask

  task automatic t_isz();
    goto(12'h500);
    reg_inc = 4'h3;
    step(8'h75); step(8'h10);
    chk("R8 nonzero jumps", pc, 12'h510);
    goto(12'h500);
    reg_inc = 4'h0;
    step(8'h75); step(8'h10);
    chk("R8 zero falls through", pc, 12'h502);
  endtask

  task automatic t_jin();
    goto(12'h640);
    pair_val = 8'h0A;
    step(8'h3D);
    chk("R9 indirect", pc, 12'h60A);
  endtask

  task automatic t_stack();
    do_reset();
    word = 8'hC7; word_vld = 1'b1; #1;
    chk("R11 acc_wr", acc_wr, 1);
    chk("R11 acc_data", acc_data, 7);
    @(posedge clk); @(negedge clk); word_vld = 1'b0;
    chk("R12 empty after reset", pc, 12'h000);
    word = 8'h00; word_vld = 1'b1; #1;
    chk("R11 acc_wr idle", acc_wr, 0);
    @(posedge clk); @(negedge clk); word_vld = 1'b0;
    goto(12'h100);
    step(8'h55); step(8'h00); chk("R10 call", pc, 12'h500);
    step(8'h56); step(8'h00);
    step(8'h57); step(8'h00);
    step(8'h58); step(8'h00); chk("R10 call4", pc, 12'h800);
    step(8'hC1); chk("R12 pop1", pc, 12'h702);
    step(8'hC2); chk("R12 pop2", pc, 12'h602);
    step(8'hC3); chk("R12 pop3", pc, 12'h502);
    step(8'hC4); chk("R12 underflow", pc, 12'h502);
    goto(12'h100);
    step(8'h55); step(8'h00);
    do_reset();
    step(8'hC0); chk("R1 stack cleared", pc, 12'h000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_seq();
    t_hold();
    t_fim();
    t_long();
    t_cond();
    t_page();
    t_isz();
    t_jin();
    t_stack();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule